// File: doc/BRIEF.md
# Word Shifter with Carry Flag

This block is a combinational shift unit for 32-bit words. It shifts left logically, right logically or right arithmetically, and it also counts leading zeros. The shift count comes either from a 6-bit value read from a register or from a 5-bit immediate field, and one select input picks between the two. A count from a register may be 32 or more. In that case bit 5 of the count drives the word fully to zero, or fully to copies of its sign bit.

On an arithmetic right shift the unit also reports a carry flag and raises a carry-write enable. The carry is set only when the operand is negative and at least one of the bits shifted out was a one. Logical shifts and the leading-zero count leave the carry alone, so their write enable stays low. The surrounding datapath owns the register file and the status register.

Top module: `wsh_word_shifter`

## Requirements
- R1: With op_i = 2'b00 (logical left), the result is the operand shifted left by amount_i[4:0], filling with zeros, whenever the register count has bit 5 clear or the immediate source is selected.
- R2: With op_i = 2'b01 (logical right), the result is the operand shifted right by amount_i[4:0], filling with zeros, under the same source conditions as R1.
- R3: With a register count (amt_from_imm_i = 0) whose bit 5 is set, both logical shifts return zero.
- R4: With op_i = 2'b10 (arithmetic right) and a count from 1 to 31, the vacated upper bits take the value of operand bit 31.
- R5: An arithmetic right shift with a register count whose bit 5 is set returns all ones for a negative operand and zero otherwise.
- R6: For an arithmetic right shift by 1 to 31, carry_o is 1 exactly when operand bit 31 is 1 and at least one shifted-out bit is 1.
- R7: For the case in R5, carry_o is 1 exactly when operand bit 31 is 1 and at least one of bits 30 down to 0 is 1.
- R8: An arithmetic right shift by zero, from either source, returns the operand unchanged with carry_o = 0.
- R9: When amt_from_imm_i = 1, amount_i[5] is ignored and the count is amount_i[4:0].
- R10: With op_i = 2'b11 (leading-zero count), the result is 32 for a zero operand and otherwise 31 minus the index of the highest set bit, zero-extended.
- R11: carry_we_o is 1 only for op_i = 2'b10, and carry_o is 0 whenever carry_we_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Word to shift or to count |
| amount_i | input | 6 | Shift count; bit 5 is used only with a register source |
| amt_from_imm_i | input | 1 | 1 selects an immediate count (low 5 bits only) |
| op_i | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 leading zeros |
| result_o | output | 32 | Shifted word or leading-zero count |
| carry_o | output | 1 | Carry value for an arithmetic right shift |
| carry_we_o | output | 1 | Carry-write enable |

## Verification
The assertions are evaluated on settled combinational values. They take for granted that op_i, amount_i and amt_from_imm_i always hold known 0/1 values and that op_i uses only its four defined codes. The stimulus never leaves any input undriven. It runs every operation and both count sources over all 64 values of amount_i. For the operands it uses the hard corner words: zero, all ones, the lone sign bit, the largest positive value, and a few mixed patterns.

// File: rtl/wsh_pkg.sv
// Package: shared operation codes for the word shifter.
// Assumes the operation code is two bits wide; all four codes are defined.
package wsh_pkg;

    typedef enum logic [1:0] {
        WSH_SLL = 2'b00,
        WSH_SRL = 2'b01,
        WSH_SRA = 2'b10,
        WSH_CLZ = 2'b11
    } wsh_op_e;

endpackage

// File: rtl/wsh_amount_sel.sv
// Module: wsh_amount_sel
// Splits the raw shift count into the in-range count and an oversize flag.
// Assumes AMT_W = CNT_W + 1; an immediate count never carries the top bit.
module wsh_amount_sel #(
    parameter int CNT_W = 5,
    localparam int AMT_W = CNT_W + 1
) (
    input  logic [AMT_W-1:0] amount_i,
    input  logic             from_imm_i,
    output logic [CNT_W-1:0] count_o,
    output logic             oversize_o
);

    // Select the low bits as the count, and flag a register count of DATA_W or more.
    always_comb begin
        count_o    = amount_i[CNT_W-1:0];
        oversize_o = !from_imm_i && amount_i[CNT_W];
    end

endmodule

// File: rtl/wsh_barrel.sv
// Module: wsh_barrel
// Logarithmic shifter. It handles left shifts by reversing the bits on the way
// in and on the way out, so that one right-shift tree serves every direction.
// Assumes DATA_W is a power of two and CNT_W = log2(DATA_W).
module wsh_barrel #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              left_i,
    input  logic              arith_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] stage [0:CNT_W];
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic              fill;

    // Mirror the operand and the tree output bit by bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rev
        assign rev_in[b]  = data_i[DATA_W-1-b];
        assign rev_out[b] = stage[CNT_W][DATA_W-1-b];
    end

    // Fill with the sign bit only for an arithmetic right shift.
    assign fill     = arith_i && !left_i && data_i[DATA_W-1];
    assign stage[0] = left_i ? rev_in : data_i;

    // One stage for each count bit: shift right by 2**k when bit k is set.
    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stage[k+1] = count_i[k]
                          ? {{SH{fill}}, stage[k][DATA_W-1:SH]}
                          : stage[k];
    end

    // Undo the mirror for left shifts.
    assign data_o = left_i ? rev_out : stage[CNT_W];

endmodule

// File: rtl/wsh_sra_carry.sv
// Module: wsh_sra_carry
// Works out the carry for an arithmetic right shift: whether a negative word
// loses a one bit. Assumes count_i == 0 means no bits leave the word.
module wsh_sra_carry #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              oversize_i,
    output logic              carry_o
);

    logic [DATA_W-1:0] lost_mask;
    logic              lost_any;

    // Mask of the bit positions that the shift drops off the low end.
    always_comb begin
        lost_mask = ~({DATA_W{1'b1}} << count_i);
        if (oversize_i)
            lost_any = |data_i[DATA_W-2:0];
        else
            lost_any = |(data_i & lost_mask);
        carry_o = data_i[DATA_W-1] && lost_any;
    end

    // A carry may appear only for a negative operand (R6, R7).
    always_comb begin
        p_carry_neg_r6: assert (!carry_o || data_i[DATA_W-1])
            else $error("carry without negative operand");
    end

endmodule

// File: rtl/wsh_clz.sv
// Module: wsh_clz
// Leading-zero counter. Returns DATA_W for a zero word.
// Assumes the output is CNT_W+1 bits wide, wide enough to hold DATA_W.
module wsh_clz #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CNT_W:0]    count_o
);

    logic [CNT_W-1:0] msb_pos;
    logic             any_set;

    // Scan upward so the highest set bit is the one that wins.
    always_comb begin
        msb_pos = '0;
        any_set = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data_i[i]) begin
                msb_pos = CNT_W'(i);
                any_set = 1'b1;
            end
        end
        count_o = any_set ? (CNT_W+1)'(DATA_W - 1 - int'(msb_pos))
                          : (CNT_W+1)'(DATA_W);
    end

    // Edge cases of the count: an empty word and a word with its top bit set (R10).
    always_comb begin
        p_clz_empty_r10: assert (|data_i || count_o == (CNT_W+1)'(DATA_W))
            else $error("zero word must count full width");
        p_clz_top_r10: assert (!data_i[DATA_W-1] || count_o == '0)
            else $error("top bit set must count zero");
    end

endmodule

// File: rtl/wsh_word_shifter.sv
// Module: wsh_word_shifter (top)
// A combinational word shifter with three shift modes and a leading-zero count.
// Arithmetic right shifts also yield a carry and a carry-write enable.
// Assumes op_i is always one of the four codes in wsh_pkg and that every
// input holds a known value.
module wsh_word_shifter #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W),
    localparam int AMT_W = CNT_W + 1
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [AMT_W-1:0]  amount_i,
    input  logic              amt_from_imm_i,
    input  logic [1:0]        op_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              carry_we_o
);
    import wsh_pkg::*;

    wsh_op_e           op;
    logic [CNT_W-1:0]  count;
    logic              oversize;
    logic [DATA_W-1:0] shifted;
    logic              sra_carry;
    logic [CNT_W:0]    lz_count;
    logic              is_left;
    logic              is_arith;

    // Decode the operation code into steering controls.
    always_comb begin
        op       = wsh_op_e'(op_i);
        is_left  = (op == WSH_SLL);
        is_arith = (op == WSH_SRA);
    end

    wsh_amount_sel #(.CNT_W(CNT_W)) u_amt (
        .amount_i   (amount_i),
        .from_imm_i (amt_from_imm_i),
        .count_o    (count),
        .oversize_o (oversize)
    );

    wsh_barrel #(.DATA_W(DATA_W)) u_bar (
        .data_i  (operand_i),
        .count_i (count),
        .left_i  (is_left),
        .arith_i (is_arith),
        .data_o  (shifted)
    );

    wsh_sra_carry #(.DATA_W(DATA_W)) u_cry (
        .data_i     (operand_i),
        .count_i    (count),
        .oversize_i (oversize),
        .carry_o    (sra_carry)
    );

    wsh_clz #(.DATA_W(DATA_W)) u_clz (
        .data_i  (operand_i),
        .count_o (lz_count)
    );

    // Pick the result for the operation and apply the oversize rules.
    always_comb begin
        result_o   = '0;
        carry_o    = 1'b0;
        carry_we_o = 1'b0;
        unique case (op)
            WSH_SLL, WSH_SRL: begin
                result_o = oversize ? '0 : shifted;
            end
            WSH_SRA: begin
                result_o   = oversize ? {DATA_W{operand_i[DATA_W-1]}} : shifted;
                carry_o    = sra_carry;
                carry_we_o = 1'b1;
            end
            default: begin
                result_o = {{(DATA_W-CNT_W-1){1'b0}}, lz_count};
            end
        endcase
    end

    // Port-level checks on the oversize, zero-count and enable behaviour.
    always_comb begin
        p_logic_oversize_r3: assert (!((op_i == 2'b00 || op_i == 2'b01) &&
                                       !amt_from_imm_i && amount_i[CNT_W]) ||
                                     result_o == '0)
            else $error("oversize logical shift must give zero");
        p_sra_oversize_r5: assert (!(op_i == 2'b10 && !amt_from_imm_i && amount_i[CNT_W]) ||
                                   result_o == {DATA_W{operand_i[DATA_W-1]}})
            else $error("oversize arithmetic shift must give sign fill");
        p_sra_zero_r8: assert (!(op_i == 2'b10 && amount_i[CNT_W-1:0] == '0 &&
                                 (amt_from_imm_i || !amount_i[CNT_W])) ||
                               (result_o == operand_i && !carry_o))
            else $error("zero arithmetic shift must be identity");
        p_carry_gated_r11: assert (carry_we_o || !carry_o)
            else $error("carry without write enable");
    end

endmodule

// File: tb/wsh_word_shifter_tb_top.sv
// Bench for wsh_word_shifter. A behavioural reference model computes the
// expected outputs. Inputs change just after the rising edge, and the outputs
// are compared at the following falling edge.
module wsh_word_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand;
    logic [5:0]  amount;
    logic        from_imm;
    logic [1:0]  op;
    logic [31:0] result;
    logic        carry;
    logic        carry_we;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    wsh_word_shifter dut_i (
        .operand_i      (operand),
        .amount_i       (amount),
        .amt_from_imm_i (from_imm),
        .op_i           (op),
        .result_o       (result),
        .carry_o        (carry),
        .carry_we_o     (carry_we)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Reference model for all four operations.
    task automatic model(input logic [1:0] o, input logic [31:0] x, input logic [5:0] a,
                         input logic imm, output logic [31:0] r, output logic c,
                         output logic we);
        int n;
        n  = imm ? int'(a[4:0]) : int'(a);
        r  = '0;
        c  = 1'b0;
        we = 1'b0;
        case (o)
            2'b00: r = (n >= 32) ? 32'h0 : (x << n);
            2'b01: r = (n >= 32) ? 32'h0 : (x >> n);
            2'b10: begin
                we = 1'b1;
                if (n >= 32) begin
                    r = x[31] ? 32'hFFFF_FFFF : 32'h0;
                    c = x[31] && ((x & 32'h7FFF_FFFF) != 0);
                end else begin
                    r = 32'($signed(x) >>> n);
                    c = x[31] && (n > 0) && ((x << (32 - n)) != 0);
                end
            end
            default: begin
                r = 32;
                for (int i = 0; i < 32; i++) if (x[i]) r = 31 - i;
            end
        endcase
    endtask

    // Requirement tag for the result check of a given stimulus.
    function automatic string tag_res(input logic [1:0] o, input logic [5:0] a, input logic imm);
        if (o == 2'b11) return "R10";
        if (imm && a[5]) return "R9";
        if (o == 2'b10) begin
            if (!imm && a[5]) return "R5";
            if (a[4:0] == 0) return "R8";
            return "R4";
        end
        if (!imm && a[5]) return "R3";
        return (o == 2'b00) ? "R1" : "R2";
    endfunction

    function automatic string tag_cry(input logic [1:0] o, input logic [5:0] a, input logic imm);
        if (o != 2'b10) return "R11";
        if (!imm && a[5]) return "R7";
        if (a[4:0] == 0) return "R8";
        return "R6";
    endfunction

    // Apply one stimulus, then compare all three outputs at the falling edge.
    task automatic apply(input logic [1:0] o, input logic [31:0] x, input logic [5:0] a,
                         input logic imm);
        logic [31:0] er;
        logic        ec;
        logic        ew;
        @(posedge clk);
        #1;
        op = o; operand = x; amount = a; from_imm = imm;
        model(o, x, a, imm, er, ec, ew);
        @(negedge clk);
        checks = checks + 1;
        if (result !== er) begin
            errors = errors + 1;
            $display("FAIL %s result op=%0d x=%h a=%0d imm=%0d: actual %h expected %h",
                     tag_res(o, a, imm), o, x, a, imm, result, er);
        end
        checks = checks + 1;
        if (carry !== ec) begin
            errors = errors + 1;
            $display("FAIL %s carry op=%0d x=%h a=%0d imm=%0d: actual %b expected %b",
                     tag_cry(o, a, imm), o, x, a, imm, carry, ec);
        end
        checks = checks + 1;
        if (carry_we !== ew) begin
            errors = errors + 1;
            $display("FAIL R11 carry_we op=%0d: actual %b expected %b", o, carry_we, ew);
        end
    endtask

    logic [31:0] pats [0:9];

    initial begin
        pats[0] = 32'h0000_0000; pats[1] = 32'h8000_0000; pats[2] = 32'hFFFF_FFFF;
        pats[3] = 32'h0000_0001; pats[4] = 32'h7FFF_FFFF; pats[5] = 32'h1234_5678;
        pats[6] = 32'h8000_0001; pats[7] = 32'hF000_0000; pats[8] = 32'hA5A5_A5A5;
        pats[9] = 32'h0001_0000;
        op = 2'b00; operand = '0; amount = '0; from_imm = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 R2 R3 R4 R5 R6 R7 R8 R9 R11: every shift op, both sources, all 64 counts.
        for (int p = 0; p < 10; p++)
            for (int o = 0; o < 3; o++)
                for (int s = 0; s < 2; s++)
                    for (int a = 0; a < 64; a++)
                        apply(2'(o), pats[p], 6'(a), s[0]);
        // R10: leading-zero count on the patterns and on each single-bit word.
        for (int p = 0; p < 10; p++) apply(2'b11, pats[p], 6'd0, 1'b0);
        for (int b = 0; b < 32; b++) apply(2'b11, 32'h1 << b, 6'h3F, 1'b1);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule